// File: doc/BRIEF.md
# Configuration key store controller

This block keeps the two symmetric keys that a bitstream decryption engine may use. One is a device key fixed at build time by a parameter. No port can write it. The other is a rewritable device key, modelled as a register that stands in for non-volatile storage.

The rewritable key is loaded one 32-bit word at a time, from either of two sources:
- an external configuration port;
- a write-only port driven from the programmable fabric.

Each port fills its own staging area. The new key takes effect only on a commit strobe, and only if every word was written since that port's last commit. When both ports act in the same cycle, the external port wins and the fabric action is dropped.

No path reads either key back except the key stream to the decryption engine. That stream uses a valid/ready handshake:
- The engine may hold ready low for as long as it likes.
- While ready is low, the presented key and its valid flag stay frozen.
- A new load request is not accepted until the pending key has been taken.

Each load request says whether the configuration is encrypted and which key it uses. An encrypted load selects either the fixed key or the rewritable key. Selecting a rewritable key that was never programmed yields an error pulse instead of a key. Once an encrypted configuration has received its key, readback and partial-reconfiguration requests are refused until a plaintext load is accepted.

Top module: `keystore_ctrl`

## Requirements
- R1: An encrypted load with `load_use_var`=0 presents exactly the `FIXED_KEY` parameter on `key_data`, with `key_valid` high, in the cycle after acceptance; no port alters that key.
- R2: A word write with index k sets staged bits [32k+31:32k], with word 0 at the LSB. A commit replaces the rewritable key with the staged key only if all 8 indices were written on that port since its previous commit. A commit with any word missing leaves the key unchanged. Every commit clears that port's written-word record.
- R3: An encrypted load with `load_use_var`=1 presents the most recently committed rewritable key.
- R4: When the external port has a write or commit in the same cycle as the fabric port, the fabric action has no effect, and `fab_drop` is high in the following cycle.
- R5: `var_programmed` is low after reset, goes high in the cycle after the first successful commit, and never falls afterwards.
- R6: An encrypted load with `load_use_var`=1 while `var_programmed` is low pulses `load_err` for one cycle after acceptance. In that case `key_valid` stays low and `enc_active` is unchanged.
- R7: While `key_valid` is high and `key_ready` is low, `key_valid` and `key_data` hold their values, `load_ready` is low, and commits do not alter the presented key.
- R8: `enc_active` goes high in the cycle after the key handshake of an encrypted load, and low in the cycle after a plaintext load (`load_encrypted`=0) is accepted.
- R9: A `readback_req` or `partial_req` gives `access_reject` in the next cycle if `enc_active` is high, and otherwise `access_grant`.
- R10: `key_data` is all zeros whenever `key_valid` is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_wr_en | input | 1 | External port word write strobe |
| ext_wr_idx | input | 3 | External port word index |
| ext_wr_data | input | 32 | External port word data |
| ext_commit | input | 1 | External port commit strobe |
| fab_wr_en | input | 1 | Fabric port word write strobe |
| fab_wr_idx | input | 3 | Fabric port word index |
| fab_wr_data | input | 32 | Fabric port word data |
| fab_commit | input | 1 | Fabric port commit strobe |
| fab_drop | output | 1 | Fabric action in previous cycle was discarded |
| var_programmed | output | 1 | Rewritable key has been committed at least once |
| load_valid | input | 1 | Configuration load request valid |
| load_ready | output | 1 | Load request can be accepted |
| load_encrypted | input | 1 | Load is an encrypted configuration |
| load_use_var | input | 1 | 1 selects rewritable key, 0 selects fixed key |
| load_err | output | 1 | Unprogrammed rewritable key was selected |
| key_valid | output | 1 | Key presented to decryption engine |
| key_ready | input | 1 | Decryption engine takes the key |
| key_data | output | 256 | Key to the decryption engine |
| enc_active | output | 1 | Encrypted configuration is active |
| readback_req | input | 1 | Configuration readback request |
| partial_req | input | 1 | Partial reconfiguration request |
| access_grant | output | 1 | Request allowed |
| access_reject | output | 1 | Request refused |

## Verification
A staging record that forgets a word shows up at the first load that selects the rewritable key: the bench compares every bit of `key_data` there against a key it computes itself. The same comparison exposes a commit that should have been refused, because a wrong key then reaches the engine.

A wrong arbitration decision shows as a missing `fab_drop` one cycle after the collision. It also shows later, as a fabric-staged key that was wrongly accepted at the next commit. A stale encryption flag shows one cycle after any readback request, as the wrong grant or reject pulse.

// File: rtl/keystore_pkg.sv
package keystore_pkg;
  localparam int KS_WORD_W = 32;
  typedef enum logic {LD_IDLE, LD_PRESENT} ld_state_e;
endpackage

// File: rtl/ks_stage.sv
module ks_stage #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 8,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     commit,
  output logic [NWORDS*WORD_W-1:0] staged,
  output logic                     commit_ok
);
  logic [NWORDS-1:0] seen;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(gi));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged[gi*WORD_W +: WORD_W] <= '0;
        seen[gi] <= 1'b0;
      end else begin
        if (hit) staged[gi*WORD_W +: WORD_W] <= wr_data;
        if (commit)   seen[gi] <= 1'b0;
        else if (hit) seen[gi] <= 1'b1;
      end
    end
  end

  assign commit_ok = commit && (&seen);

  p_seen_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (seen == '0));
endmodule

// File: rtl/ks_arb.sv
module ks_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_act,
  input  logic fab_act,
  output logic fab_pass,
  output logic fab_drop
);
  assign fab_pass = fab_act && !ext_act;

  always_ff @(posedge clk) begin
    if (!rst_n) fab_drop <= 1'b0;
    else        fab_drop <= fab_act && ext_act;
  end

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_act && fab_act) |=> fab_drop);
  p_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_act && fab_act) |=> !fab_drop);
endmodule

// File: rtl/ks_varkey.sv
module ks_varkey #(
  parameter int KEY_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_ok,
  input  logic [KEY_W-1:0] ext_key,
  input  logic             fab_ok,
  input  logic [KEY_W-1:0] fab_key,
  output logic [KEY_W-1:0] var_key,
  output logic             programmed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      var_key    <= '0;
      programmed <= 1'b0;
    end else if (ext_ok) begin
      var_key    <= ext_key;
      programmed <= 1'b1;
    end else if (fab_ok) begin
      var_key    <= fab_key;
      programmed <= 1'b1;
    end
  end

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    programmed |=> programmed);
  p_atomic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_ok || fab_ok) |=> $stable(var_key));
endmodule

// File: rtl/ks_load.sv
module ks_load
  import keystore_pkg::*;
#(
  parameter int KEY_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic             load_encrypted,
  input  logic             load_use_var,
  output logic             load_ready,
  output logic             load_err,
  input  logic [KEY_W-1:0] fixed_key,
  input  logic [KEY_W-1:0] var_key,
  input  logic             programmed,
  output logic             key_valid,
  input  logic             key_ready,
  output logic [KEY_W-1:0] key_data,
  output logic             enc_active,
  input  logic             readback_req,
  input  logic             partial_req,
  output logic             access_grant,
  output logic             access_reject
);
  ld_state_e state;
  logic      any_req;

  assign load_ready = (state == LD_IDLE);
  assign key_valid  = (state == LD_PRESENT);
  assign any_req    = readback_req || partial_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= LD_IDLE;
      key_data   <= '0;
      enc_active <= 1'b0;
      load_err   <= 1'b0;
    end else begin
      load_err <= 1'b0;
      case (state)
        LD_IDLE: if (load_valid) begin
          if (!load_encrypted) begin
            enc_active <= 1'b0;
          end else if (load_use_var && !programmed) begin
            load_err <= 1'b1;
          end else begin
            key_data <= load_use_var ? var_key : fixed_key;
            state    <= LD_PRESENT;
          end
        end
        LD_PRESENT: if (key_ready) begin
          key_data   <= '0;
          enc_active <= 1'b1;
          state      <= LD_IDLE;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access_grant  <= 1'b0;
      access_reject <= 1'b0;
    end else begin
      access_grant  <= any_req && !enc_active;
      access_reject <= any_req && enc_active;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_data)));
  p_err_no_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !key_valid);
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && enc_active) |=> (access_reject && !access_grant));
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> (key_data == '0));
  p_enc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> enc_active);
endmodule

// File: rtl/keystore_ctrl.sv
module keystore_ctrl
  import keystore_pkg::*;
#(
  parameter int KEY_W = 256,
  parameter int WORD_W = KS_WORD_W,
  parameter logic [KEY_W-1:0] FIXED_KEY =
    256'h6D2B_91F0_3C7E_A548_0B1D_E9C2_7F34_56A1_C0FF_EE12_8844_2299_3A5B_7C9D_E1F2_0415,
  localparam int NWORDS = KEY_W / WORD_W,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_wr_en,
  input  logic [IDX_W-1:0]  ext_wr_idx,
  input  logic [WORD_W-1:0] ext_wr_data,
  input  logic              ext_commit,
  input  logic              fab_wr_en,
  input  logic [IDX_W-1:0]  fab_wr_idx,
  input  logic [WORD_W-1:0] fab_wr_data,
  input  logic              fab_commit,
  output logic              fab_drop,
  output logic              var_programmed,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic              load_encrypted,
  input  logic              load_use_var,
  output logic              load_err,
  output logic              key_valid,
  input  logic              key_ready,
  output logic [KEY_W-1:0]  key_data,
  output logic              enc_active,
  input  logic              readback_req,
  input  logic              partial_req,
  output logic              access_grant,
  output logic              access_reject
);
  logic             fab_pass;
  logic [KEY_W-1:0] ext_staged, fab_staged, var_key;
  logic             ext_ok, fab_ok;

  ks_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .ext_act(ext_wr_en || ext_commit),
    .fab_act(fab_wr_en || fab_commit),
    .fab_pass(fab_pass), .fab_drop(fab_drop)
  );

  ks_stage #(.WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_ext_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ext_wr_en), .wr_idx(ext_wr_idx), .wr_data(ext_wr_data),
    .commit(ext_commit), .staged(ext_staged), .commit_ok(ext_ok)
  );

  ks_stage #(.WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_fab_stage (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fab_wr_en && fab_pass), .wr_idx(fab_wr_idx), .wr_data(fab_wr_data),
    .commit(fab_commit && fab_pass), .staged(fab_staged), .commit_ok(fab_ok)
  );

  ks_varkey #(.KEY_W(KEY_W)) u_varkey (
    .clk(clk), .rst_n(rst_n),
    .ext_ok(ext_ok), .ext_key(ext_staged),
    .fab_ok(fab_ok), .fab_key(fab_staged),
    .var_key(var_key), .programmed(var_programmed)
  );

  ks_load #(.KEY_W(KEY_W)) u_load (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_encrypted(load_encrypted),
    .load_use_var(load_use_var), .load_ready(load_ready), .load_err(load_err),
    .fixed_key(FIXED_KEY), .var_key(var_key), .programmed(var_programmed),
    .key_valid(key_valid), .key_ready(key_ready), .key_data(key_data),
    .enc_active(enc_active),
    .readback_req(readback_req), .partial_req(partial_req),
    .access_grant(access_grant), .access_reject(access_reject)
  );

  p_fixed_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready && load_encrypted && !load_use_var) |=> (key_data == FIXED_KEY));
endmodule

// File: tb/keystore_ctrl_bench.sv
module keystore_ctrl_bench;
  localparam logic [255:0] FIX =
    256'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90_1122_3344_5566_7788_99AA_BBCC_DDEE_FF00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_wr_en = 0, ext_commit = 0, fab_wr_en = 0, fab_commit = 0;
  logic [2:0] ext_wr_idx = 0, fab_wr_idx = 0;
  logic [31:0] ext_wr_data = 0, fab_wr_data = 0;
  logic load_valid = 0, load_encrypted = 0, load_use_var = 0, key_ready = 0;
  logic readback_req = 0, partial_req = 0;
  logic fab_drop, var_programmed, load_ready, load_err, key_valid, enc_active;
  logic access_grant, access_reject;
  logic [255:0] key_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keystore_ctrl #(.FIXED_KEY(FIX)) u_keystore_ctrl (.*);

  function automatic logic [31:0] pat(int seed, int k);
    return 32'(seed * 32'h0100_0193 + k * 32'h9E37_79B9 + 32'h5A5A_0000);
  endfunction

  function automatic logic [255:0] mk_key(int seed);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = pat(seed, k);
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit fab, input int idx, input logic [31:0] d);
    @(negedge clk);
    if (fab) begin fab_wr_en = 1; fab_wr_idx = 3'(idx); fab_wr_data = d; end
    else     begin ext_wr_en = 1; ext_wr_idx = 3'(idx); ext_wr_data = d; end
    @(negedge clk);
    fab_wr_en = 0; ext_wr_en = 0;
  endtask

  task automatic cmt(input bit fab);
    @(negedge clk);
    if (fab) fab_commit = 1; else ext_commit = 1;
    @(negedge clk);
    fab_commit = 0; ext_commit = 0;
  endtask

  task automatic write_key(input bit fab, input int seed, input int nw);
    for (int k = 0; k < nw; k++) wr(fab, k, pat(seed, k));
  endtask

  task automatic do_load(input bit use_var, input bit enc);
    @(negedge clk);
    load_valid = 1; load_use_var = use_var; load_encrypted = enc;
    @(negedge clk);
    load_valid = 0;
  endtask

  task automatic take_key();
    @(negedge clk);
    key_ready = 1;
    @(negedge clk);
    key_ready = 0;
  endtask

  task automatic acc(input bit partial, input bit exp_rej, input string req);
    @(negedge clk);
    if (partial) partial_req = 1; else readback_req = 1;
    @(negedge clk);
    partial_req = 0; readback_req = 0;
    chk(req, {254'b0, access_reject, access_grant}, {254'b0, exp_rej, !exp_rej});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R10 reset key_data", key_data, '0);
    chk("R5 reset programmed", 256'(var_programmed), 0);
    chk("R8 reset enc_active", 256'(enc_active), 0);
    chk("R7 reset load_ready", 256'(load_ready), 1);
    chk("R4 reset fab_drop", 256'(fab_drop), 0);

    // unprogrammed variable key selected
    do_load(1, 1);
    chk("R6 err pulse", 256'(load_err), 1);
    chk("R6 no key", 256'(key_valid), 0);
    chk("R6 enc unchanged", 256'(enc_active), 0);
    @(negedge clk);
    chk("R6 err one cycle", 256'(load_err), 0);

    // fixed key load with back-pressure
    do_load(0, 1);
    chk("R1 fixed key", key_data, FIX);
    chk("R1 key_valid", 256'(key_valid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 hold data", key_data, FIX);
      chk("R7 ready low", 256'(load_ready), 0);
    end
    take_key();
    chk("R8 enc set", 256'(enc_active), 1);
    chk("R10 zero after take", key_data, '0);
    acc(0, 1, "R9 readback rejected");
    acc(1, 1, "R9 partial rejected");

    // error load while encrypted keeps flag
    do_load(1, 1);
    chk("R6 err keeps enc", 256'(enc_active), 1);

    // plaintext load clears flag
    do_load(0, 0);
    chk("R8 enc cleared", 256'(enc_active), 0);
    chk("R8 no key on plaintext", 256'(key_valid), 0);
    acc(0, 0, "R9 readback granted");
    acc(1, 0, "R9 partial granted");

    // incomplete key commit refused
    write_key(0, 7, 7);
    cmt(0);
    chk("R2 partial not committed", 256'(var_programmed), 0);
    chk("R5 still unprogrammed", 256'(var_programmed), 0);

    // sweep over seeds and both ports
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        write_key(p[0], s * 2 + p, 8);
        cmt(p[0]);
        chk("R5 programmed", 256'(var_programmed), 1);
        do_load(1, 1);
        chk("R3 variable key", key_data, mk_key(s * 2 + p));
        take_key();
        do_load(0, 1);
        chk("R1 fixed after var", key_data, FIX);
        take_key();
      end
    end

    // partial overwrite on fabric refused; previous key (seed 7) remains
    write_key(1, 20, 3);
    cmt(1);
    do_load(1, 1);
    chk("R2 partial fabric ignored", key_data, mk_key(7));
    take_key();

    // collisions: external wins on every cycle
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ext_wr_en = 1; ext_wr_idx = 3'(k); ext_wr_data = pat(30, k);
      fab_wr_en = 1; fab_wr_idx = 3'(k); fab_wr_data = pat(31, k);
      @(negedge clk);
      ext_wr_en = 0; fab_wr_en = 0;
      chk("R4 drop flagged", 256'(fab_drop), 1);
    end
    @(negedge clk);
    ext_commit = 1; fab_commit = 1;
    @(negedge clk);
    ext_commit = 0; fab_commit = 0;
    chk("R4 commit drop", 256'(fab_drop), 1);
    do_load(1, 1);
    chk("R4 external wins", key_data, mk_key(30));
    take_key();
    cmt(1);
    chk("R4 no drop alone", 256'(fab_drop), 0);
    do_load(1, 1);
    chk("R4 fabric writes discarded", key_data, mk_key(30));

    // commit while key pending does not disturb the presented key
    write_key(0, 40, 8);
    cmt(0);
    chk("R7 pending key stable", key_data, mk_key(30));
    take_key();
    do_load(1, 1);
    chk("R3 new key after pending", key_data, mk_key(40));
    take_key();
    chk("R5 stays programmed", 256'(var_programmed), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule